// File: doc/BRIEF.md
# Self-ID Reception Status Register

This block tracks the outcome of the self-identification phase that follows every serial bus reset. Bus-side logic reports events as single-cycle pulses: a bus reset was seen, a self-ID reception started, a quadlet was stored in the self-ID buffer, a reception ended (with or without a hardware error), or a host write into the buffer failed. From these the block keeps three fields: a sticky error flag, a wrapping reset generation count and a quadlet count.

The fields are packed into one 32-bit word that the host register interface reads combinationally. The host cannot change any field by writing. Each update rule, priority and bit position is fixed in hardware; widths and positions are parameters, checked at elaboration.

Top module: `sid_status_reg`

## Requirements
- R1: After reset the read word is 32'h0000_0000.
- R2: Every bit outside bit 31, bits 23:16 and bits 10:2 of the read word is always 0.
- R3: An end-of-reception pulse that carries a hardware error sets the error flag (bit 31) on the next clock edge.
- R4: A host write error pulse sets the error flag on the next clock edge, even if an error-free end of reception occurs in the same cycle.
- R5: The error flag is cleared only by an error-free end of reception with no host write error in that cycle. In every other cycle it keeps its value.
- R6: The generation count (bits 23:16) rises by one on each bus reset pulse and wraps from 255 to 0. It does not change in other cycles.
- R7: The quadlet count (bits 10:2) rises by one for each quadlet-written pulse. This covers the header quadlet and the data quadlets alike.
- R8: A reception-start pulse clears the quadlet count. If a quadlet-written pulse arrives in the same cycle, the count becomes 1.
- R9: The quadlet count stops at 511 and does not wrap.
- R10: A host write strobe has no effect on any field of the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_reset_i | input | 1 | Pulse: bus reset detected |
| rx_start_i | input | 1 | Pulse: self-ID reception begins |
| quad_wr_i | input | 1 | Pulse: one quadlet written to the self-ID buffer |
| rx_done_i | input | 1 | Pulse: self-ID reception ended |
| rx_err_i | input | 1 | Qualifies rx_done_i: a hardware error occurred |
| host_wr_err_i | input | 1 | Pulse: a host bus write into the buffer failed |
| host_wr_i | input | 1 | Host write strobe to this register (ignored) |
| rd_data_o | output | 32 | Composed status word |

## Verification
Random event streams mix every pulse at different densities. Because events often coincide, these streams separate the set-over-clear priority and the clear-over-increment priority from simple independent updates. Directed sequences then cover three corners: 256 bus resets, to show that the generation count wraps rather than saturates; more than 511 quadlets, to show that the count saturates rather than wraps; and host write strobes alone, so that any leak from a write into a field shows at the port. Each cycle, every field is compared with a bench model, and the reserved bits are checked as well, so a field landing at the wrong bit position is reported.

// File: rtl/sid_pkg.sv
package sid_pkg;
   typedef enum logic {CNT_SATURATE = 1'b0, CNT_WRAP = 1'b1} cnt_mode_e;
   localparam int DEF_WORD_W  = 32;
   localparam int DEF_GEN_W   = 8;
   localparam int DEF_CNT_W   = 9;
   localparam int DEF_ERR_POS = 31;
   localparam int DEF_GEN_LSB = 16;
   localparam int DEF_CNT_LSB = 2;
endpackage

// File: rtl/sid_err_flag.sv
module sid_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_done_i,
   input  logic rx_err_i,
   input  logic host_wr_err_i,
   output logic err_o
);
   logic set_c, clr_c;

   assign set_c = (rx_done_i & rx_err_i) | host_wr_err_i;
   assign clr_c = rx_done_i & ~rx_err_i;

   always_ff @(posedge clk) begin
      if (!rst_n)      err_o <= 1'b0;
      else if (set_c)  err_o <= 1'b1;
      else if (clr_c)  err_o <= 1'b0;
   end

   assert_err_hw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done_i && rx_err_i) |=> err_o);
   assert_err_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_err_i |=> err_o);
   assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done_i && !rx_err_i && !host_wr_err_i) |=> !err_o);
   assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_done_i && !host_wr_err_i) |=> $stable(err_o));
endmodule

// File: rtl/sid_gen_ctr.sv
module sid_gen_ctr #(
   parameter int GEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_reset_i,
   output logic [GEN_W-1:0] gen_o
);
   generate
      if (GEN_W < 1 || GEN_W > 16) begin : g_bad_w
         $error("sid_gen_ctr: GEN_W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)           gen_o <= '0;
      else if (bus_reset_i) gen_o <= gen_o + GEN_W'(1);
   end

   assert_gen_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> gen_o == GEN_W'($past(gen_o) + GEN_W'(1)));
   assert_gen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_reset_i |=> $stable(gen_o));
endmodule

// File: rtl/sid_quad_ctr.sv
module sid_quad_ctr
   import sid_pkg::*;
#(
   parameter int        CNT_W    = 9,
   parameter cnt_mode_e CNT_MODE = CNT_SATURATE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_start_i,
   input  logic             quad_wr_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   logic [CNT_W-1:0] inc_c;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
         $error("sid_quad_ctr: CNT_W out of range");
      end
      if (CNT_MODE == CNT_SATURATE) begin : g_sat
         assign inc_c = (cnt_o == CNT_MAX) ? cnt_o : cnt_o + CNT_W'(1);
      end else begin : g_wrap
         assign inc_c = cnt_o + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_o <= '0;
      else if (rx_start_i) cnt_o <= quad_wr_i ? CNT_W'(1) : '0;
      else if (quad_wr_i)  cnt_o <= inc_c;
   end

   assert_cnt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_start_i |=> cnt_o == ($past(quad_wr_i) ? CNT_W'(1) : CNT_W'(0)));
   assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_start_i && !quad_wr_i) |=> $stable(cnt_o));
   generate
      if (CNT_MODE == CNT_SATURATE) begin : g_sat_chk
         assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_o == CNT_MAX && !rx_start_i) |=> cnt_o == CNT_MAX);
      end
   endgenerate
endmodule

// File: rtl/sid_status_reg.sv
module sid_status_reg
   import sid_pkg::*;
#(
   parameter int        WORD_W   = DEF_WORD_W,
   parameter int        GEN_W    = DEF_GEN_W,
   parameter int        CNT_W    = DEF_CNT_W,
   parameter int        ERR_POS  = DEF_ERR_POS,
   parameter int        GEN_LSB  = DEF_GEN_LSB,
   parameter int        CNT_LSB  = DEF_CNT_LSB,
   parameter cnt_mode_e CNT_MODE = CNT_SATURATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset_i,
   input  logic              rx_start_i,
   input  logic              quad_wr_i,
   input  logic              rx_done_i,
   input  logic              rx_err_i,
   input  logic              host_wr_err_i,
   input  logic              host_wr_i,
   output logic [WORD_W-1:0] rd_data_o
);
   localparam int GEN_MSB = GEN_LSB + GEN_W - 1;
   localparam int CNT_MSB = CNT_LSB + CNT_W - 1;
   localparam logic [WORD_W-1:0] FIELD_MASK =
      (WORD_W'(1) << ERR_POS) |
      (((WORD_W'(1) << GEN_W) - WORD_W'(1)) << GEN_LSB) |
      (((WORD_W'(1) << CNT_W) - WORD_W'(1)) << CNT_LSB);

   generate
      if (ERR_POS >= WORD_W || GEN_MSB >= ERR_POS || CNT_MSB >= GEN_LSB) begin : g_bad_layout
         $error("sid_status_reg: fields overlap or exceed the word");
      end
   endgenerate

   logic             err_q;
   logic [GEN_W-1:0] gen_q;
   logic [CNT_W-1:0] cnt_q;

   sid_err_flag u_err (
      .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done_i), .rx_err_i(rx_err_i),
      .host_wr_err_i(host_wr_err_i), .err_o(err_q)
   );

   sid_gen_ctr #(.GEN_W(GEN_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .gen_o(gen_q)
   );

   sid_quad_ctr #(.CNT_W(CNT_W), .CNT_MODE(CNT_MODE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rx_start_i(rx_start_i), .quad_wr_i(quad_wr_i),
      .cnt_o(cnt_q)
   );

   always_comb begin
      rd_data_o                       = '0;
      rd_data_o[ERR_POS]              = err_q;
      rd_data_o[GEN_LSB +: GEN_W]     = gen_q;
      rd_data_o[CNT_LSB +: CNT_W]     = cnt_q;
   end

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o & ~FIELD_MASK) == '0);
   assert_host_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_i && !bus_reset_i && !rx_start_i && !quad_wr_i && !rx_done_i
       && !host_wr_err_i) |=> $stable(rd_data_o));
   assert_reset_word_R1: assert property (@(posedge clk)
      !rst_n |=> rd_data_o == '0);
endmodule

// File: tb/sid_status_reg_bench.sv
`timescale 1ns/1ps
module sid_status_reg_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_reset_i, rx_start_i, quad_wr_i, rx_done_i, rx_err_i;
   logic        host_wr_err_i, host_wr_i;
   logic [31:0] rd_data_o;

   int checks = 0;
   int errors = 0;
   bit e_err;
   bit [7:0] e_gen;
   bit [8:0] e_cnt;

   always #5 clk = ~clk;

   sid_status_reg u_sid_status_reg (
      .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .rx_start_i(rx_start_i),
      .quad_wr_i(quad_wr_i), .rx_done_i(rx_done_i), .rx_err_i(rx_err_i),
      .host_wr_err_i(host_wr_err_i), .host_wr_i(host_wr_i), .rd_data_o(rd_data_o)
   );

   function automatic bit f_err(bit cur, bit done, bit herr, bit hwerr);
      if ((done && herr) || hwerr) return 1'b1;
      if (done) return 1'b0;
      return cur;
   endfunction

   function automatic bit [7:0] f_gen(bit [7:0] cur, bit br);
      return br ? cur + 8'd1 : cur;
   endfunction

   function automatic bit [8:0] f_cnt(bit [8:0] cur, bit st, bit qw);
      if (st) return qw ? 9'd1 : 9'd0;
      if (qw) return (cur == 9'd511) ? cur : cur + 9'd1;
      return cur;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_word(input string tag);
      logic [31:0] exp;
      exp = {e_err, 7'd0, e_gen, 5'd0, e_cnt, 2'd0};
      chk(rd_data_o[31] == e_err, {tag, " R3/R4/R5 error flag bit31"}, rd_data_o, exp);
      chk(rd_data_o[23:16] == e_gen, {tag, " R6 generation bits23:16"}, rd_data_o, exp);
      chk(rd_data_o[10:2] == e_cnt, {tag, " R7/R8/R9 count bits10:2"}, rd_data_o, exp);
      chk((rd_data_o & 32'h7F00_F803) == 32'd0, {tag, " R2 reserved bits"}, rd_data_o, exp);
   endtask

   task automatic step(input bit br, input bit st, input bit qw, input bit dn,
                       input bit he, input bit hwe, input bit hw, input string tag);
      @(negedge clk);
      bus_reset_i = br; rx_start_i = st; quad_wr_i = qw; rx_done_i = dn;
      rx_err_i = he; host_wr_err_i = hwe; host_wr_i = hw;
      @(posedge clk);
      e_err = f_err(e_err, dn, he, hwe);
      e_gen = f_gen(e_gen, br);
      e_cnt = f_cnt(e_cnt, st, qw);
      #1;
      check_word(tag);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit [31:0] r;
      void'($urandom(32'h51D0_2024));
      rst_n = 1'b0;
      bus_reset_i = 0; rx_start_i = 0; quad_wr_i = 0; rx_done_i = 0;
      rx_err_i = 0; host_wr_err_i = 0; host_wr_i = 0;
      e_err = 0; e_gen = 0; e_cnt = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(rd_data_o == 32'd0, "R1 reset word", rd_data_o, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R7 header plus data quadlets, R8 start clears
      step(1,0,0,0,0,0,0, "dir R6 reset");
      step(0,1,0,0,0,0,0, "dir R8 start");
      for (int i = 0; i < 4; i++) step(0,0,1,0,0,0,0, "dir R7 quadlet");
      chk(rd_data_o[10:2] == 9'd4, "R7 four quadlets", rd_data_o, 32'h10);
      step(0,1,1,0,0,0,0, "dir R8 start+quad");
      chk(rd_data_o[10:2] == 9'd1, "R8 start with quadlet gives 1", rd_data_o, 32'h4);
      // R3 hardware error, R5 hold and clear
      step(0,0,0,1,1,0,0, "dir R3 hw error");
      chk(rd_data_o[31] == 1'b1, "R3 flag set", rd_data_o, 32'h8000_0000);
      step(0,1,1,0,0,0,0, "dir R5 hold over start");
      chk(rd_data_o[31] == 1'b1, "R5 flag held", rd_data_o, 32'h8000_0000);
      step(0,0,0,1,0,0,0, "dir R5 clean done");
      chk(rd_data_o[31] == 1'b0, "R5 flag cleared", rd_data_o, 32'h0);
      // R4 set beats clear
      step(0,0,0,1,0,1,0, "dir R4 set vs clear");
      chk(rd_data_o[31] == 1'b1, "R4 host error wins", rd_data_o, 32'h8000_0000);
      // R10 host writes alone
      for (int i = 0; i < 5; i++) step(0,0,0,0,0,0,1, "dir R10 host write");
      // R9 saturation
      step(0,1,0,0,0,0,0, "dir R9 start");
      for (int i = 0; i < 520; i++) step(0,0,1,0,0,0,0, "dir R9 fill");
      chk(rd_data_o[10:2] == 9'd511, "R9 saturated at 511", rd_data_o, 32'h7FC);
      // R6 wrap
      for (int i = 0; i < 256; i++) step(1,0,0,0,0,0,0, "dir R6 wrap");
      chk(rd_data_o[23:16] == e_gen, "R6 wrapped to start value", rd_data_o, {8'd0, e_gen, 16'd0});

      // random phase
      for (int i = 0; i < 4000; i++) begin
         r = $urandom;
         step(r[3:0] == 0, r[7:4] == 0, r[9:8] != 0, r[13:11] == 0, r[14],
              r[19:15] == 0, r[20], "rand");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule